// File: doc/BRIEF.md
# Network Status LED Driver

This block turns network status lines into three LED outputs. The first LED always shows whether the link is up. Each of the other two LEDs has its own enable mask over seven status sources. The block ORs the sources that are enabled for that LED into one activity signal.

Each programmable LED can follow its activity signal directly. It can also pass through a pulse stretcher, so that short bursts of activity still produce a visible flash. The stretcher is a short shift register. Activity loads it with ones. A slow periodic tick, about 38 Hz and derived from the system clock, then shifts zeros in.

The status inputs come from other clock domains. They are resynchronised before use. The configuration inputs are captured into registers that clear on reset.

Top module: `led_status_drv`

## Requirements
- R1: `led_o[0]` shows link state. It turns on after `link_ok_i` is high and turns off after it is low, within three clock cycles.
- R2: While `rst_ni` is low, every bit of `led_o` is 0.
- R3: `status_i` bit order is: 0 collision, 1 jabber, 2 receive, 3 receive polarity good, 4 transmit, 5 receive address match, 6 full-duplex link. Programmable LED k (output bit k+1, k = 0 or 1) lights when any source s has both `status_i[s]` and enable bit `src_en_i[k*7+s]` set.
- R4: A status source whose enable bit is clear has no effect on the LED that enable bit belongs to.
- R5: The two programmable LEDs use independent masks. A source enabled for only one LED lights only that LED.
- R6: With `stretch_en_i[k]` clear, LED k+1 follows its activity signal. It goes off within four cycles after the activity ends.
- R7: With `stretch_en_i[k]` set, LED k+1 lights while activity is present. After the activity ends, it stays on for at least two and at most three tick periods of CLK_HZ/TICK_HZ cycles. It goes off only on a tick.
- R8: Activity that reappears while a stretched LED is still on reloads the stretcher. The LED stays on without a gap and the hold time restarts from the new end of activity.
- R9: The tick pulse is one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_ok_i | input | 1 | Link good status, asynchronous |
| status_i | input | 7 | Programmable status sources, asynchronous, order per R3 |
| src_en_i | input | 14 | Per-LED source enables, 7 bits per programmable LED |
| stretch_en_i | input | 2 | Per-LED stretcher select |
| led_o | output | 3 | LED drive, bit 0 link, bits 1-2 programmable |

## Verification
The bench walks a single enabled source across all seven bit positions. It then drives every source except the enabled one. A design with a swapped mask index or an inverted enable lights the wrong LED or fails to light. It cross-wires the two masks to catch outputs that share state.

It measures the stretched hold time in cycles against the two-to-three-tick window. A stretcher with the wrong depth, or one that shifts in ones, falls outside that window. A second pulse sent during the hold checks for a gap and for a restarted hold time. A design that ignores the reload gives a short second hold.

// File: rtl/led_pkg.sv
package led_pkg;
  // source order: col, jab, rcv, rx_pol_ok, xmt, addr_match, fdx_link
  localparam int unsigned N_SRC = 7;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/led_sync.sv
module led_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R9
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic tick_i,
  input  logic en_i,
  output logic led_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (act_i)  sr_q <= '1;
    else if (tick_i) sr_q <= {sr_q[DEPTH-2:0], 1'b0};
  end

  assign led_o = en_i ? sr_q[DEPTH-1] : act_i;

  // R7
  set_on_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> sr_q[DEPTH-1]);
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && !tick_i) |=> $stable(sr_q));
  // R7
  fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sr_q[DEPTH-1]) |-> $past(tick_i));
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_pkg::*;
#(
  parameter int unsigned N_PROG   = 2,
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned TICK_HZ  = 38,
  parameter int unsigned SR_DEPTH = 3,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    link_ok_i,
  input  logic [N_SRC-1:0]        status_i,
  input  logic [N_PROG*N_SRC-1:0] src_en_i,
  input  logic [N_PROG-1:0]       stretch_en_i,
  output logic [N_PROG:0]         led_o
);
  localparam int unsigned TICK_DIV = CLK_HZ / TICK_HZ;

  logic [N_PROG*N_SRC-1:0] en_q;
  logic [N_PROG-1:0]       str_q;
  logic                    link_s;
  src_vec_t                stat_s;
  logic                    tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      str_q <= '0;
    end else begin
      en_q  <= src_en_i;
      str_q <= stretch_en_i;
    end
  end

  led_sync #(.W(N_SRC + 1), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({link_ok_i, status_i}),
    .q_o   ({link_s, stat_s})
  );

  led_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign led_o[0] = link_s;

  for (genvar k = 0; k < N_PROG; k++) begin : g_prog
    logic act;
    assign act = |(stat_s & en_q[k*N_SRC +: N_SRC]);

    led_stretch #(.DEPTH(SR_DEPTH)) u_str (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (act),
      .tick_i(tick),
      .en_i  (str_q[k]),
      .led_o (led_o[k+1])
    );
  end

  // R1
  link_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(led_o[0]) |-> $past(link_ok_i, 2));
  // R1
  link_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(led_o[0]) |-> !$past(link_ok_i, 2));
endmodule

// File: tb/led_status_drv_tb.sv
`timescale 1ns/1ps
module led_status_drv_tb;
  localparam int DIV = 10;
  localparam int HOLD_MIN = 2*DIV + 3;
  localparam int HOLD_MAX = 3*DIV + 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        link_ok = 0;
  logic [6:0]  status = '0;
  logic [13:0] src_en = '0;
  logic [1:0]  stretch_en = '0;
  logic [2:0]  led;

  int checks = 0;
  int fails  = 0;
  bit done_run = 0;

  typedef struct { logic [2:0] exp; string tag; } item_t;
  item_t exp_q[$];
  event  item_done;

  always #5 clk = ~clk;

  led_status_drv #(.CLK_HZ(380), .TICK_HZ(38)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .link_ok_i(link_ok), .status_i(status),
    .src_en_i(src_en), .stretch_en_i(stretch_en), .led_o(led)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: apply stimulus, push expected LED vector
  task automatic drive(input logic lk, input logic [6:0] st, input logic [13:0] en,
                       input logic [1:0] str, input logic [2:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    link_ok = lk; status = st; src_en = en; stretch_en = str;
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    @(item_done);
  endtask

  // monitor: settle past sync+config+stretch latency, then compare
  initial begin
    forever begin
      item_t it;
      wait (exp_q.size() > 0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      it = exp_q.pop_front();
      check(32'(led), 32'(it.exp), it.tag);
      ->item_done;
    end
  end

  task automatic measure_hold(input string tag);
    int n = 0;
    bit gap = 0;
    @(negedge clk);
    status = '0;
    while (led[1] && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    checks++;
    if (n < HOLD_MIN || n > HOLD_MAX || gap) begin
      fails++;
      $display("FAIL %s hold actual=%0d expected=%0d..%0d", tag, n, HOLD_MIN, HOLD_MAX);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R2: reset holds everything off even with inputs active
    link_ok = 1; status = '1; src_en = '1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(32'(led), 0, "R2 reset");
    link_ok = 0; status = '0; src_en = '0;
    rst_n = 1;

    // R1
    drive(1, '0, '0, '0, 3'b001, "R1 link up");
    drive(0, '0, '0, '0, 3'b000, "R1 link down");

    // R4: all sources active, no enables
    drive(0, 7'h7F, '0, '0, 3'b000, "R4 no enables");

    // R3/R4: walk each source on LED1
    for (int s = 0; s < 7; s++) begin
      drive(0, 7'(1 << s), 14'(1 << s), '0, 3'b010, $sformatf("R3 src%0d", s));
      drive(0, ~7'(1 << s), 14'(1 << s), '0, 3'b000, $sformatf("R4 src%0d masked", s));
    end
    // R3 on LED2
    drive(0, 7'h20, 14'h20 << 7, '0, 3'b100, "R3 led2 addr match");

    // R5: independent masks
    drive(0, 7'h10, {7'h10, 7'h01}, '0, 3'b100, "R5 xmt only led2");
    drive(1, 7'h01, {7'h10, 7'h01}, '0, 3'b011, "R5 col only led1");

    // R6: bypass drops promptly
    drive(0, 7'h04, 14'h04, '0, 3'b010, "R6 bypass on");
    drive(0, 7'h00, 14'h04, '0, 3'b000, "R6 bypass off");

    // R7: stretched hold window
    drive(0, 7'h02, 14'h02, 2'b01, 3'b010, "R7 stretch on");
    measure_hold("R7");

    // R8: retrigger during hold, no gap, hold restarts
    drive(0, 7'h02, 14'h02, 2'b01, 3'b010, "R8 first pulse");
    @(negedge clk); status = '0;
    begin
      bit gap = 0;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (!led[1]) gap = 1;
      end
      status = 7'h02;
      repeat (3) begin
        @(negedge clk);
        if (!led[1]) gap = 1;
      end
      check(32'(gap), 0, "R8 no gap");
    end
    measure_hold("R8");

    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule